// File: doc/BRIEF.md
# Multi-channel programmable interval timer

This block holds six independent down-counting timer channels behind a plain register port. The port has a write strobe and a read strobe, both sampled on the clock edge. Each channel has three registers: a control word, an interval (reload) value and a live count. A channel's tick comes from one of four clock-enable inputs. That input is divided by a power-of-two prescaler from 1 to 128. Each channel runs either periodically, reloading from its interval on expiry, or once. A one-shot channel stops at zero and clears its own enable bit.

Two shared registers sit at the bottom of the map, each with one bit per channel. The first is an interrupt mask. The second is an interrupt status register, and writing a 1 to a bit clears it. Each channel drives its own interrupt output, which is the AND of its status bit and its mask bit. Software programs an interval, selects a source, a divider and a mode, and sets the enable bit. It then services the interrupt by writing the status bit back.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset the mask register, the status register, every interval and every count read 0. Every control word reads 0x04 (source 1, divider 1, stopped, periodic). All interrupt outputs are low.
- R2: The byte map is as follows. Mask is at 0x00 and status at 0x04. Channel k (0..5) has control at 0x10*(k+1)+0x0, interval at +0x4 and count at +0x8. Any other offset, including bits above [7:0] set, reads 0. Writes to such offsets change no register.
- R3: Interrupt output k is high exactly when status bit k and mask bit k are both 1. Clearing a mask bit drops that output while the status bit stays set.
- R4: A write to the status register clears each bit written as 1 and keeps bits written as 0. An expiry in the same cycle as a clear of that bit leaves the bit set.
- R5: Writing a channel's interval stores the value and loads the counter with it in the same cycle.
- R6: The control word is laid out as follows: bit 0 is enable, bit 1 is reload, bits [3:2] are the source, bits [6:4] are the divider exponent n, and bit 7 is the mode (1 for one-shot). A control write with bit 1 set loads the counter from the interval. Bit 1 always reads back as 0.
- R7: An enabled channel decrements once per 2^n high cycles of its selected clock-enable input. It ignores the other three inputs. Changing the source or the exponent restarts the divider.
- R8: In periodic mode, a tick that finds the count at 1 or 0 sets the status bit and reloads the interval. The channel keeps running.
- R9: In one-shot mode, a tick that finds the count at 1 or 0 sets the status bit, leaves the count at 0 and clears enable. The channel then ignores further ticks.
- R10: A channel with enable 0 holds its count.
- R11: A write to the count register does not change the count that reads back.
- R12: Read data appears on rdata_o in the cycle after the read strobe. In every other cycle rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| src_tick_i | input | 4 | Four clock-enable tick sources |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 10 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 6 | One interrupt per channel |

## Verification
The hardest case to reach is an expiry that lands in the same cycle as a software clear of that channel's status bit. The stimulus gets there in two steps. It first brings a periodic channel down to a count of 1 using single source pulses. It then raises the source input in the same cycle that it writes 1 to the status bit, and checks that the bit stays set. A second awkward case is the one-shot self-stop. After the stop, extra source pulses are applied to show that the count stays at 0 and the control word reads back with enable cleared.

// File: rtl/tick_timer_bank.sv
module tick_timer_bank #(
  parameter int NCH     = 6,
  parameter int DW      = 32,
  parameter int AW      = 10,
  parameter int DEF_SRC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    src_tick_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [NCH-1:0] irq_o
);
  localparam int PW  = 3;
  localparam int PCW = 2**PW - 1;
  localparam logic [7:0] DEF_CTRL = 8'(DEF_SRC << 2);

  logic [NCH-1:0] ien_q, ist_q;
  logic [7:0]     ctrl_q [NCH];
  logic [DW-1:0]  ival_q [NCH];
  logic [DW-1:0]  cnt_q  [NCH];
  logic [PCW-1:0] pcnt_q [NCH];
  logic [PCW-1:0] msk    [NCH];

  logic [3:0] grp, sub;
  logic       in_rng;
  logic       wr_ien, wr_ist;
  logic [NCH-1:0] wr_ctrl, wr_ival, ch_wr, src_on, tick, expire, rst_div;
  logic [DW-1:0]  rd_mux;

  assign grp    = addr_i[7:4];
  assign sub    = addr_i[3:0];
  assign in_rng = (addr_i[AW-1:8] == '0);
  assign wr_ien = wr_en_i && in_rng && grp == 4'd0 && sub == 4'h0;
  assign wr_ist = wr_en_i && in_rng && grp == 4'd0 && sub == 4'h4;
  assign irq_o  = ist_q & ien_q;

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      wr_ctrl[k] = wr_en_i && in_rng && grp == 4'(k + 1) && sub == 4'h0;
      wr_ival[k] = wr_en_i && in_rng && grp == 4'(k + 1) && sub == 4'h4;
      ch_wr[k]   = wr_ctrl[k] || wr_ival[k];
      src_on[k]  = src_tick_i[ctrl_q[k][3:2]];
      msk[k]     = PCW'((PCW + 1)'(1) << ctrl_q[k][6:4]) - 1'b1;
      tick[k]    = ctrl_q[k][0] && src_on[k] && pcnt_q[k] == msk[k] && !ch_wr[k];
      expire[k]  = tick[k] && cnt_q[k] <= DW'(1);
      rst_div[k] = !wdata_i[0] || wdata_i[6:2] != ctrl_q[k][6:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) begin
        ctrl_q[k] <= DEF_CTRL;
        ival_q[k] <= '0;
        cnt_q[k]  <= '0;
        pcnt_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NCH; k++) begin
        if (wr_ctrl[k]) begin
          ctrl_q[k] <= {wdata_i[7:2], 1'b0, wdata_i[0]};
          if (wdata_i[1]) cnt_q[k] <= ival_q[k];
          if (rst_div[k]) pcnt_q[k] <= '0;
        end else if (wr_ival[k]) begin
          ival_q[k] <= wdata_i;
          cnt_q[k]  <= wdata_i;
        end else begin
          if (!ctrl_q[k][0]) pcnt_q[k] <= '0;
          else if (src_on[k]) pcnt_q[k] <= (pcnt_q[k] == msk[k]) ? '0 : pcnt_q[k] + 1'b1;
          if (tick[k]) begin
            if (!expire[k]) cnt_q[k] <= cnt_q[k] - 1'b1;
            else if (ctrl_q[k][7]) begin
              cnt_q[k]     <= '0;
              ctrl_q[k][0] <= 1'b0;
            end else cnt_q[k] <= ival_q[k];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q <= '0;
      ist_q <= '0;
    end else begin
      if (wr_ien) ien_q <= wdata_i[NCH-1:0];
      ist_q <= (wr_ist ? (ist_q & ~wdata_i[NCH-1:0]) : ist_q) | expire;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_rng && grp == 4'd0) begin
      if (sub == 4'h0) rd_mux = DW'(ien_q);
      else if (sub == 4'h4) rd_mux = DW'(ist_q);
    end
    for (int k = 0; k < NCH; k++) begin
      if (in_rng && grp == 4'(k + 1)) begin
        if (sub == 4'h0) rd_mux = DW'(ctrl_q[k]);
        else if (sub == 4'h4) rd_mux = ival_q[k];
        else if (sub == 4'h8) rd_mux = cnt_q[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rd_en_i ? rd_mux : '0;
  end

  p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> rdata_o == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    p_oneshot_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[g] && ctrl_q[g][7]) |=> (!ctrl_q[g][0] && cnt_q[g] == '0));
    p_periodic_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[g] && !ctrl_q[g][7]) |=> (cnt_q[g] == $past(ival_q[g]) && ctrl_q[g][0]));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[g][0] && !wr_ival[g] && !(wr_ctrl[g] && wdata_i[1])) |=> $stable(cnt_q[g]));
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ist_q[g] && !(wr_ist && wdata_i[g])) |=> ist_q[g]);
    p_mask_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ien && !wdata_i[g]) |=> !irq_o[g]);
  end
endmodule

// File: tb/tick_timer_bank_tb.sv
module tick_timer_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  src_tick_i = '0;
  logic        wr_en_i = 0, rd_en_i = 0;
  logic [9:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [5:0]  irq_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rv;

  tick_timer_bank dut_i (.clk(clk), .rst_n(rst_n), .src_tick_i(src_tick_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); rd_en_i = 1; addr_i = a;
    @(negedge clk); rd_en_i = 0; d = rdata_o;
  endtask

  task automatic pulse(int s, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src_tick_i[s] = 1;
      @(negedge clk); src_tick_i[s] = 0;
    end
  endtask

  task automatic t_reset();
    rd(10'h000, rv); check("R1 mask", rv, 0);
    rd(10'h004, rv); check("R1 status", rv, 0);
    rd(10'h010, rv); check("R1 ctrl0", rv, 32'h04);
    rd(10'h060, rv); check("R1 ctrl5", rv, 32'h04);
    rd(10'h034, rv); check("R1 interval2", rv, 0);
    rd(10'h058, rv); check("R1 count4", rv, 0);
    check("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_interval();
    wr(10'h034, 32'h1234);
    rd(10'h034, rv); check("R5 interval", rv, 32'h1234);
    rd(10'h038, rv); check("R5 count", rv, 32'h1234);
  endtask

  task automatic t_decode();
    wr(10'h008, 32'h3f);
    wr(10'h100, 32'h3f);
    wr(10'h070, 32'h3f);
    rd(10'h000, rv); check("R2 mask untouched", rv, 0);
    rd(10'h008, rv); check("R2 undefined top", rv, 0);
    rd(10'h070, rv); check("R2 undefined group", rv, 0);
    rd(10'h01c, rv); check("R2 undefined slot", rv, 0);
    rd(10'h110, rv); check("R2 high bits", rv, 0);
    rd(10'h010, rv); check("R2 ctrl0 untouched", rv, 32'h04);
  endtask

  task automatic t_prescale();
    wr(10'h014, 10);
    wr(10'h010, 32'h25);
    pulse(0, 8);
    rd(10'h018, rv); check("R7 other source ignored", rv, 10);
    pulse(1, 8);
    rd(10'h018, rv); check("R7 divide by 4", rv, 8);
  endtask

  task automatic t_stopped();
    wr(10'h010, 32'h24);
    pulse(1, 8);
    rd(10'h018, rv); check("R10 hold", rv, 8);
    wr(10'h018, 32'h99);
    rd(10'h018, rv); check("R11 count write", rv, 8);
  endtask

  task automatic t_reload();
    wr(10'h014, 5);
    wr(10'h010, 32'h05);
    pulse(1, 2);
    rd(10'h018, rv); check("R7 divide by 1", rv, 3);
    wr(10'h010, 32'h07);
    rd(10'h018, rv); check("R6 reload", rv, 5);
    rd(10'h010, rv); check("R6 reload bit reads 0", rv, 32'h05);
    wr(10'h010, 32'h04);
  endtask

  task automatic t_periodic();
    wr(10'h024, 3);
    wr(10'h020, 32'h05);
    wr(10'h000, 32'h02);
    pulse(1, 2);
    check("R3 irq before expiry", 32'(irq_o), 0);
    pulse(1, 1);
    check("R3 irq after expiry", 32'(irq_o), 32'h02);
    rd(10'h028, rv); check("R8 reload", rv, 3);
    pulse(1, 1);
    rd(10'h028, rv); check("R8 keeps running", rv, 2);
    wr(10'h000, 32'h00);
    check("R3 masked", 32'(irq_o), 0);
    rd(10'h004, rv); check("R3 status kept", rv, 32'h02);
    wr(10'h000, 32'h02);
  endtask

  task automatic t_clear();
    wr(10'h004, 32'h01);
    rd(10'h004, rv); check("R4 zero bits kept", rv, 32'h02);
    wr(10'h004, 32'h02);
    rd(10'h004, rv); check("R4 cleared", rv, 0);
    check("R4 irq low", 32'(irq_o), 0);
    pulse(1, 1);
    @(negedge clk); wr_en_i = 1; addr_i = 10'h004; wdata_i = 32'h02; src_tick_i[1] = 1;
    @(negedge clk); wr_en_i = 0; src_tick_i[1] = 0;
    rd(10'h004, rv); check("R4 expiry beats clear", rv, 32'h02);
    rd(10'h028, rv); check("R8 reload on collision", rv, 3);
    wr(10'h004, 32'h02);
    wr(10'h020, 32'h04);
  endtask

  task automatic t_oneshot();
    wr(10'h044, 2);
    wr(10'h040, 32'h85);
    pulse(1, 2);
    rd(10'h048, rv); check("R9 count zero", rv, 0);
    rd(10'h010 + 10'h030, rv); check("R9 enable cleared", rv, 32'h84);
    rd(10'h004, rv); check("R9 status", rv, 32'h08);
    pulse(1, 2);
    rd(10'h048, rv); check("R9 stays stopped", rv, 0);
  endtask

  task automatic t_rdata();
    rd(10'h044, rv); check("R12 read data", rv, 2);
    @(negedge clk); check("R12 idle zero", rdata_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_interval();
    t_decode();
    t_prescale();
    t_stopped();
    t_reload();
    t_periodic();
    t_clear();
    t_oneshot();
    t_rdata();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule